// File: doc/BRIEF.md
# Pointer-Indexed Channel Register File

This block is the processor-facing register access logic of one serial channel. The bus reaches it through two addresses, a control address and a data address. A 3-bit pointer held in the low bits of configuration register 0 selects the target of every control access. A control write lands in one of eight configuration registers. A control read returns one of three read registers: status, error or interrupt vector. Each access to a register other than register 0 sends the pointer back home, so the usual programming sequence is a pair of writes: first the pointer, then the value.

A command field in register 0 performs a channel reset that clears the whole channel state. On the data side, an incoming character from the receive path is held in a buffer and raises a ready flag in the status register. A data read returns the buffered character and lowers that flag. A data write hands its byte to the transmit path in the same cycle. All eight configuration registers are exposed as one flat vector for the rest of the channel to use.

Top module: `chan_regfile`

## Requirements
- R1: An active-low hard reset (`rst_n` = 0) clears all eight configuration registers, the pointer, the ready flag and the receive buffer to zero.
- R2: A control write while the pointer is 0 stores the byte in register 0 (`cfg_regs[7:0]`). Bits 2:0 of that byte become the new pointer.
- R3: A control write while the pointer is n (1 to 7) stores the byte in register n (`cfg_regs[8n+7:8n]`) and clears bits 2:0 of register 0, so the pointer returns to 0.
- R4: A control read returns, without a wait cycle, the read register chosen by the pointer. Pointer 0 gives status, with bit 0 equal to the ready flag and bits 7:1 zero. Pointers 1 and 2 give the error and vector registers, which read 0x00 because nothing in this block loads them. Pointers 3 to 7 read 0x00. A read with a nonzero pointer returns the pointer to 0.
- R5: A control write with pointer 0 and bits 5:3 equal to 3'b011 is a channel reset. It clears all eight configuration registers, including register 0, so the pointer ends at 0, and it clears the ready flag.
- R6: A receive strobe (`rx_stb` = 1) stores `rx_char` in the buffer and sets status bit 0 from the next cycle on.
- R7: A data read returns the buffered character in the same cycle and clears status bit 0 from the next cycle on.
- R8: When a receive strobe coincides with a data read, the read returns the previous character, the new character enters the buffer and status bit 0 stays set.
- R9: A data write raises `tx_stb` for that cycle with `tx_byte` equal to the written byte, and changes no configuration register.
- R10: When a receive strobe coincides with a channel reset, status bit 0 is set after the reset.
- R11: `bus_rdata` is 0x00 in any cycle without a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| bus_sel | input | 1 | Bus access strobe for this channel, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ctrl | input | 1 | 1 = control address, 0 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_stb | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| tx_stb | output | 1 | Byte handed to the transmit path |
| tx_byte | output | 8 | Byte for the transmit path |
| cfg_regs | output | 64 | Configuration registers 7..0, register n at bits 8n+7:8n |

## Verification
The pointer path is driven through every register index. Each index is preceded by its own pointer write, which separates a wrong slice from a pointer that fails to return home. Status reads are placed between a pointer write and the return to pointer 0, while the ready flag is set. A read of 0x00 there rather than 0x01 shows that the pointer, not the status, picked the data. Receive strobes are combined with data writes, data reads and channel-reset commands in the same cycle, which tells apart the priority rules of R8 and R10. The reset command is also sent with nonzero pointer and high bits, to show that register 0 does not keep the written byte.

// File: rtl/crf_pkg.sv
package crf_pkg;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_CTRL_WR,
      ACC_CTRL_RD,
      ACC_DATA_WR,
      ACC_DATA_RD
   } acc_e;

   function automatic acc_e classify(input logic sel, input logic wr, input logic ctrl);
      if (!sel)
         return ACC_NONE;
      if (ctrl)
         return wr ? ACC_CTRL_WR : ACC_CTRL_RD;
      return wr ? ACC_DATA_WR : ACC_DATA_RD;
   endfunction

endpackage

// File: rtl/crf_access_decode.sv
module crf_access_decode
   import crf_pkg::*;
(
   input  logic bus_sel,
   input  logic bus_wr,
   input  logic bus_ctrl,
   output logic ctrl_wr,
   output logic ctrl_rd,
   output logic data_wr,
   output logic data_rd
);
   acc_e kind;

   always_comb begin
      kind    = classify(bus_sel, bus_wr, bus_ctrl);
      ctrl_wr = (kind == ACC_CTRL_WR);
      ctrl_rd = (kind == ACC_CTRL_RD);
      data_wr = (kind == ACC_DATA_WR);
      data_rd = (kind == ACC_DATA_RD);
   end
endmodule

// File: rtl/crf_wr_bank.sv
module crf_wr_bank #(
   parameter  int DW       = 8,
   parameter  int NWR      = 8,
   parameter  int CMD_LSB  = 3,
   parameter  int CMD_W    = 3,
   parameter  logic [CMD_W-1:0] CLR_CODE = 3'b011,
   localparam int PW       = $clog2(NWR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic              ctrl_rd,
   input  logic [DW-1:0]     wdata,
   output logic [PW-1:0]     ptr,
   output logic              chan_clr,
   output logic [NWR*DW-1:0] regs_flat
);
   if ((1 << PW) != NWR || NWR < 2) begin : g_bad_nwr
      $error("crf_wr_bank: NWR must be a power of two, at least 2");
   end
   if (CMD_LSB < PW || DW < CMD_LSB + CMD_W) begin : g_bad_fields
      $error("crf_wr_bank: pointer and command fields must be disjoint and fit in DW");
   end

   logic [DW-1:0] reg0_q;
   logic          ptr_home;

   assign ptr      = reg0_q[PW-1:0];
   assign chan_clr = ctrl_wr && (ptr == '0) && (wdata[CMD_LSB +: CMD_W] == CLR_CODE);
   assign ptr_home = (ctrl_wr || ctrl_rd) && (ptr != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg0_q <= '0;
      else if (chan_clr)
         reg0_q <= '0;
      else if (ctrl_wr && (ptr == '0))
         reg0_q <= wdata;
      else if (ptr_home)
         reg0_q[PW-1:0] <= '0;
   end
   assign regs_flat[DW-1:0] = reg0_q;

   for (genvar i = 1; i < NWR; i++) begin : g_reg
      logic [DW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r <= '0;
         else if (chan_clr)
            r <= '0;
         else if (ctrl_wr && (ptr == PW'(i)))
            r <= wdata;
      end
      assign regs_flat[i*DW +: DW] = r;
   end
endmodule

// File: rtl/crf_rx_hold.sv
module crf_rx_hold #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_stb,
   input  logic [DW-1:0] rx_char,
   input  logic          data_rd,
   input  logic          chan_clr,
   output logic [DW-1:0] rx_buf,
   output logic          rdy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf <= '0;
         rdy    <= 1'b0;
      end else begin
         if (rx_stb) begin
            rx_buf <= rx_char;
            rdy    <= 1'b1;
         end else if (data_rd || chan_clr) begin
            rdy    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/chan_regfile.sv
module chan_regfile #(
   parameter  int DW       = 8,
   parameter  int NWR      = 8,
   parameter  int NRD      = 3,
   parameter  int CMD_LSB  = 3,
   parameter  int CMD_W    = 3,
   parameter  logic [CMD_W-1:0] CLR_CODE = 3'b011,
   localparam int PW       = $clog2(NWR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_ctrl,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              rx_stb,
   input  logic [DW-1:0]     rx_char,
   output logic              tx_stb,
   output logic [DW-1:0]     tx_byte,
   output logic [NWR*DW-1:0] cfg_regs
);
   if (NRD < 1 || NRD > NWR) begin : g_bad_nrd
      $error("chan_regfile: NRD must lie in 1..NWR");
   end

   logic          ctrl_wr, ctrl_rd, data_wr, data_rd;
   logic [PW-1:0] ptr;
   logic          chan_clr;
   logic [DW-1:0] rx_buf;
   logic          rdy;
   logic [DW-1:0] rd_view [NRD];

   crf_access_decode u_dec (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_ctrl(bus_ctrl),
      .ctrl_wr (ctrl_wr),
      .ctrl_rd (ctrl_rd),
      .data_wr (data_wr),
      .data_rd (data_rd)
   );

   crf_wr_bank #(
      .DW(DW), .NWR(NWR), .CMD_LSB(CMD_LSB), .CMD_W(CMD_W), .CLR_CODE(CLR_CODE)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_wr  (ctrl_wr),
      .ctrl_rd  (ctrl_rd),
      .wdata    (bus_wdata),
      .ptr      (ptr),
      .chan_clr (chan_clr),
      .regs_flat(cfg_regs)
   );

   crf_rx_hold #(.DW(DW)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_stb  (rx_stb),
      .rx_char (rx_char),
      .data_rd (data_rd),
      .chan_clr(chan_clr),
      .rx_buf  (rx_buf),
      .rdy     (rdy)
   );

   // Read register 0 carries the ready flag; the others have no source in this block.
   for (genvar i = 0; i < NRD; i++) begin : g_rd
      if (i == 0) begin : g_status
         assign rd_view[i] = {{(DW-1){1'b0}}, rdy};
      end else begin : g_idle
         assign rd_view[i] = '0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (ctrl_rd) begin
         for (int k = 0; k < NRD; k++)
            if (ptr == PW'(k))
               bus_rdata = rd_view[k];
      end else if (data_rd) begin
         bus_rdata = rx_buf;
      end
   end

   assign tx_stb  = data_wr;
   assign tx_byte = data_wr ? bus_wdata : '0;
endmodule

// File: rtl/crf_checker.sv
module crf_checker #(
   parameter int DW  = 8,
   parameter int NWR = 8,
   parameter int NRD = 3,
   parameter int PW  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_wr,
   input logic              ctrl_rd,
   input logic              data_rd,
   input logic              rx_stb,
   input logic [DW-1:0]     rx_char,
   input logic [PW-1:0]     ptr,
   input logic              chan_clr,
   input logic              rdy,
   input logic [DW-1:0]     rx_buf,
   input logic [DW-1:0]     bus_rdata,
   input logic [NWR*DW-1:0] cfg_regs
);
   assert_ptr_home_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ptr != '0) |=> (ptr == '0));

   assert_ptr_home_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd && ptr != '0) |=> (ptr == '0));

   assert_high_ptr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd && int'(ptr) >= NRD) |-> (bus_rdata == '0));

   assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      chan_clr |=> (cfg_regs == '0));

   assert_rx_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb |=> (rdy && rx_buf == $past(rx_char)));

   assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !rx_stb) |=> !rdy);

   assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_rd || data_rd) |-> (bus_rdata == '0));
endmodule

bind chan_regfile crf_checker #(.DW(DW), .NWR(NWR), .NRD(NRD), .PW(PW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_wr  (ctrl_wr),
   .ctrl_rd  (ctrl_rd),
   .data_rd  (data_rd),
   .rx_stb   (rx_stb),
   .rx_char  (rx_char),
   .ptr      (ptr),
   .chan_clr (chan_clr),
   .rdy      (rdy),
   .rx_buf   (rx_buf),
   .bus_rdata(bus_rdata),
   .cfg_regs (cfg_regs)
);

// File: tb/chan_regfile_bench.sv
`timescale 1ns/1ps
module chan_regfile_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_ctrl = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        rx_stb = 1'b0;
   logic [7:0]  rx_char = '0;
   logic        tx_stb;
   logic [7:0]  tx_byte;
   logic [63:0] cfg_regs;

   int checks = 0;
   int failures = 0;
   logic       s_txs;
   logic [7:0] s_rd, s_txb;

   always #2.5 clk = ~clk;

   chan_regfile u_chan_regfile (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_ctrl(bus_ctrl),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_stb(rx_stb), .rx_char(rx_char),
      .tx_stb(tx_stb), .tx_byte(tx_byte), .cfg_regs(cfg_regs)
   );

   // kind: 0 control write, 1 control read, 2 data write, 3 data read
   localparam int NV = 18;
   localparam logic [26:0] VEC [NV] = '{
      {2'd1, 8'h00, 1'b0, 8'h00, 8'h00},  // R4 status idle
      {2'd2, 8'h55, 1'b1, 8'h41, 8'h55},  // R9 tx, R6 rx
      {2'd1, 8'h00, 1'b0, 8'h00, 8'h01},  // R6
      {2'd3, 8'h00, 1'b0, 8'h00, 8'h41},  // R7
      {2'd1, 8'h00, 1'b0, 8'h00, 8'h00},  // R7 flag cleared
      {2'd0, 8'h01, 1'b0, 8'h00, 8'h00},  // R2 pointer 1
      {2'd1, 8'h00, 1'b0, 8'h00, 8'h00},  // R4 error reg
      {2'd0, 8'h05, 1'b1, 8'h7E, 8'h00},  // R2 pointer 5
      {2'd1, 8'h00, 1'b0, 8'h00, 8'h00},  // R4 pointer 5 reads zero
      {2'd1, 8'h00, 1'b0, 8'h00, 8'h01},  // R4 back at status
      {2'd3, 8'h00, 1'b1, 8'h33, 8'h7E},  // R8 old char
      {2'd1, 8'h00, 1'b0, 8'h00, 8'h01},  // R8 flag kept
      {2'd3, 8'h00, 1'b0, 8'h00, 8'h33},  // R8 new char
      {2'd1, 8'h00, 1'b0, 8'h00, 8'h00},  // R7
      {2'd0, 8'h02, 1'b1, 8'h11, 8'h00},  // R2 pointer 2
      {2'd1, 8'h00, 1'b0, 8'h00, 8'h00},  // R4 vector reg
      {2'd1, 8'h00, 1'b0, 8'h00, 8'h01},  // R4 status
      {2'd3, 8'h00, 1'b0, 8'h00, 8'h11}   // R7
   };

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic op(input logic [1:0] kind, input logic [7:0] wd, input logic rx, input logic [7:0] rc);
      @(negedge clk);
      bus_sel   = 1'b1;
      bus_wr    = (kind == 2'd0) || (kind == 2'd2);
      bus_ctrl  = (kind == 2'd0) || (kind == 2'd1);
      bus_wdata = wd;
      rx_stb    = rx;
      rx_char   = rc;
      #1;
      s_rd  = bus_rdata;
      s_txs = tx_stb;
      s_txb = tx_byte;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_ctrl = 1'b0; bus_wdata = '0;
      rx_stb  = 1'b0; rx_char = '0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [63:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 cfg after reset", cfg_regs, 64'h0);
      check("R11 idle rdata", {56'h0, bus_rdata}, 64'h0);

      for (int v = 0; v < NV; v++) begin
         op(VEC[v][26:25], VEC[v][24:17], VEC[v][16], VEC[v][15:8]);
         case (VEC[v][26:25])
            2'd0: check($sformatf("R11 rdata on ctrl write row %0d", v), {56'h0, s_rd}, 64'h0);
            2'd2: begin
               check($sformatf("R9 tx_stb row %0d", v), {63'h0, s_txs}, 64'h1);
               check($sformatf("R9 tx_byte row %0d", v), {56'h0, s_txb}, {56'h0, VEC[v][7:0]});
            end
            default: check($sformatf("R4/R7/R8 rdata row %0d", v), {56'h0, s_rd}, {56'h0, VEC[v][7:0]});
         endcase
      end

      // R2 / R3: every register through its own pointer write
      for (int i = 1; i < 8; i++) begin
         op(2'd0, 8'(i), 1'b0, 8'h0);
         check("R2 reg0 holds pointer", {56'h0, cfg_regs[7:0]}, 64'(i));
         op(2'd0, 8'(8'h10 + i), 1'b0, 8'h0);
         check("R3 target slice", {56'h0, cfg_regs[i*8 +: 8]}, 64'(8'h10 + i));
         check("R3 pointer home", {61'h0, cfg_regs[2:0]}, 64'h0);
      end
      op(2'd0, 8'hA2, 1'b0, 8'h0);
      check("R2 reg0 full byte", {56'h0, cfg_regs[7:0]}, 64'hA2);
      op(2'd0, 8'h5C, 1'b0, 8'h0);
      check("R3 reg2 rewritten", {56'h0, cfg_regs[23:16]}, 64'h5C);
      check("R3 reg0 upper bits kept", {56'h0, cfg_regs[7:0]}, 64'hA0);

      // R9: data write leaves configuration untouched
      snap = cfg_regs;
      op(2'd2, 8'hC3, 1'b0, 8'h0);
      check("R9 cfg unchanged", cfg_regs, snap);

      // R5: reset command with high bits and nonzero pointer bits
      op(2'd0, 8'h00, 1'b1, 8'h66);
      op(2'd0, 8'hDF, 1'b0, 8'h0);
      check("R5 cfg cleared", cfg_regs, 64'h0);
      op(2'd1, 8'h00, 1'b0, 8'h0);
      check("R5 ready cleared", {56'h0, s_rd}, 64'h0);

      // R10: receive strobe together with the reset command
      op(2'd0, 8'h07, 1'b0, 8'h0);
      op(2'd0, 8'h77, 1'b0, 8'h0);
      op(2'd0, 8'h18, 1'b1, 8'h99);
      check("R10 cfg cleared", cfg_regs, 64'h0);
      op(2'd1, 8'h00, 1'b0, 8'h0);
      check("R10 ready set", {56'h0, s_rd}, 64'h01);
      op(2'd3, 8'h00, 1'b0, 8'h0);
      check("R10 char kept", {56'h0, s_rd}, 64'h99);

      // R1: hard reset in mid-run with state loaded
      op(2'd0, 8'h03, 1'b1, 8'h5A);
      op(2'd0, 8'hE4, 1'b0, 8'h0);
      op(2'd0, 8'h41, 1'b0, 8'h0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 cfg during reset", cfg_regs, 64'h0);
      rst_n = 1'b1;
      op(2'd1, 8'h00, 1'b0, 8'h0);
      check("R1 ready cleared", {56'h0, s_rd}, 64'h0);
      op(2'd3, 8'h00, 1'b0, 8'h0);
      check("R1 buffer cleared", {56'h0, s_rd}, 64'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule